// File: doc/BRIEF.md
# Serial Receive Start and Frame-Sync Controller

This block decides when a synchronous serial receiver captures data. It watches a frame-sync line, a start request from the transmit side and two compare-match flags. From these it decides when reception begins, how long it lasts and when it stops. It also forwards the receive clock enable, gated by the level of the frame-sync line, and generates its own periodic frame-sync pulse. It does not shift data, match patterns or talk to a bus. The data path next to it consumes `rck_gated_o` as its bit strobe and `rx_active_o` as its capture window.

All logic runs on one system clock. The receive clock appears as a one-cycle enable, `rck_en_i`. The frame-sync input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. A start event therefore reaches `rx_active_o` three clock cycles after the line changes. The start delay, the transfer length and the frame-sync period are counted in receive-clock ticks.

Top module: `rx_start_ctrl`

## Requirements
- R1: `rck_gated_o` is high only when `rck_en_i` and `rx_en_i` are both high, and the gating code in `cfg_gate_i` allows it. Code 0 always allows. Code 1 allows while the synchronized frame-sync level is low. Code 2 allows while it is high. Code 3 never allows.
- R2: Start code 0 (continuous) raises `rx_active_o` one cycle after `rx_en_i` rises. The output then stays high across the ends of transfers.
- R3: Start codes 2 (line low) and 3 (line high) start on the synchronized level. `rx_active_o` rises three cycles after the line reaches that level.
- R4: Start codes 4 (falling edge), 5 (rising edge), 6 and 7 (any change) start three cycles after the matching transition on `fs_i`. A transition of the other direction does not start the receiver.
- R5: Start code 1 starts on `tx_start_i`, raising `rx_active_o` in the cycle after the flag is sampled.
- R6: A nonzero `cfg_delay_i` of D adds exactly D receive-clock ticks between the start event and `rx_active_o`. This includes a start from the transmit side.
- R7: Outside the continuous cases, a transfer lasts `cfg_len_i`+1 gated receive ticks. After that `rx_active_o` falls.
- R8: With start code 8 and `cfg_stop_i`=0, a one-cycle `cmp0_i` pulse starts a single transfer. The receiver then stays idle until the next `cmp0_i`.
- R9: With start code 8 and `cfg_stop_i`=1, reception continues across transfers until `cmp1_i` is high. `rx_active_o` then falls in the next cycle.
- R10: With `cfg_period_i`=P and P nonzero, `fs_pulse_o` gives a one-cycle pulse every 2×(P+1) receive ticks. The first pulse comes that many ticks after enable. With P=0 there is no pulse.
- R11: Dropping `rx_en_i` clears `rx_active_o` in the next cycle. It also discards a pending start delay and restarts the frame-sync period count.
- R12: Start codes 9 to 15 never start the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| rck_en_i | input | 1 | Receive clock tick |
| fs_i | input | 1 | Frame-sync line, asynchronous |
| tx_start_i | input | 1 | Start request from the transmit side |
| cmp0_i | input | 1 | Compare-0 match flag |
| cmp1_i | input | 1 | Compare-1 match flag |
| cfg_start_i | input | 4 | Start condition code |
| cfg_stop_i | input | 1 | Compare stop mode: 0 single transfer, 1 run until compare-1 |
| cfg_delay_i | input | 8 | Start delay in receive ticks |
| cfg_period_i | input | 8 | Frame-sync period field P |
| cfg_gate_i | input | 2 | Clock gating code |
| cfg_len_i | input | 5 | Transfer length minus one, in receive ticks |
| rck_gated_o | output | 1 | Gated receive clock tick |
| rx_active_o | output | 1 | Receive window active |
| fs_pulse_o | output | 1 | Generated frame-sync pulse |

## Verification
Some properties are checked on every cycle. The gated tick never appears without a raw tick and an enabled receiver, and never appears under the reserved gating code. The receiver is inactive after any cycle with the enable low. A compare-1 match ends a compare-started continuous run one cycle later. A zero period suppresses the pulse, and two pulses never come back to back. Other behaviour is shown only by the directed scenarios. This covers the three-cycle latency through the synchronizer, edge direction selection, the exact delay and transfer lengths, the single-shot rearm, the period interval and the restart after a disable.

// File: rtl/rx_start_pkg.sv
`timescale 1ns/1ps
package rx_start_pkg;
  typedef enum logic [3:0] {
    ST_CONT = 4'd0, ST_TX   = 4'd1, ST_LOW  = 4'd2, ST_HIGH = 4'd3,
    ST_FALL = 4'd4, ST_RISE = 4'd5, ST_CHG  = 4'd6, ST_EDGE = 4'd7,
    ST_CMP0 = 4'd8
  } start_sel_e;

  typedef enum logic [1:0] {
    GT_NONE = 2'd0, GT_LOW = 2'd1, GT_HIGH = 2'd2
  } gate_sel_e;

  typedef enum logic [1:0] {
    S_IDLE, S_DELAY, S_RUN
  } rx_state_e;
endpackage

// File: rtl/rx_fs_sync.sv
`timescale 1ns/1ps
module rx_fs_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], fs_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/rx_trig_sel.sv
`timescale 1ns/1ps
module rx_trig_sel
  import rx_start_pkg::*;
(
  input  logic [3:0] start_sel_i,
  input  logic [1:0] gate_sel_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       tx_start_i,
  input  logic       cmp0_i,
  output logic       trig_o,
  output logic       gate_ok_o
);
  always_comb begin
    case (start_sel_i)
      ST_CONT:         trig_o = 1'b1;
      ST_TX:           trig_o = tx_start_i;
      ST_LOW:          trig_o = ~lvl_i;
      ST_HIGH:         trig_o = lvl_i;
      ST_FALL:         trig_o = fall_i;
      ST_RISE:         trig_o = rise_i;
      ST_CHG, ST_EDGE: trig_o = rise_i | fall_i;
      ST_CMP0:         trig_o = cmp0_i;
      default:         trig_o = 1'b0;
    endcase
  end

  always_comb begin
    case (gate_sel_i)
      GT_NONE: gate_ok_o = 1'b1;
      GT_LOW:  gate_ok_o = ~lvl_i;
      GT_HIGH: gate_ok_o = lvl_i;
      default: gate_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_period_gen.sv
`timescale 1ns/1ps
module rx_period_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pulse_o
);
  localparam int CW = PER_W + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  // 2*(P+1) ticks per frame, counter runs 0 .. 2P+1
  assign last = (CW'(period_i) << 1) + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (!en_i || period_i == '0) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == last) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rx_start_ctrl.sv
`timescale 1ns/1ps
module rx_start_ctrl
  import rx_start_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int PER_W = 8,
  parameter int LEN_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             rck_en_i,
  input  logic             fs_i,
  input  logic             tx_start_i,
  input  logic             cmp0_i,
  input  logic             cmp1_i,
  input  logic [3:0]       cfg_start_i,
  input  logic             cfg_stop_i,
  input  logic [DLY_W-1:0] cfg_delay_i,
  input  logic [PER_W-1:0] cfg_period_i,
  input  logic [1:0]       cfg_gate_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  output logic             rck_gated_o,
  output logic             rx_active_o,
  output logic             fs_pulse_o
);
  logic fs_lvl, fs_rise, fs_fall;
  logic trig, gate_ok;
  logic keep_run, stop_cmp1;

  rx_state_e        state_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [LEN_W-1:0] bcnt_q;

  rx_fs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fs_i   (fs_i),
    .lvl_o  (fs_lvl),
    .rise_o (fs_rise),
    .fall_o (fs_fall)
  );

  rx_trig_sel u_trig (
    .start_sel_i (cfg_start_i),
    .gate_sel_i  (cfg_gate_i),
    .lvl_i       (fs_lvl),
    .rise_i      (fs_rise),
    .fall_i      (fs_fall),
    .tx_start_i  (tx_start_i),
    .cmp0_i      (cmp0_i),
    .trig_o      (trig),
    .gate_ok_o   (gate_ok)
  );

  rx_period_gen #(.PER_W(PER_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .tick_i   (rck_en_i),
    .period_i (cfg_period_i),
    .pulse_o  (fs_pulse_o)
  );

  assign rck_gated_o = rx_en_i & rck_en_i & gate_ok;
  assign stop_cmp1   = (cfg_start_i == ST_CMP0) & cfg_stop_i;
  // modes that roll straight into the next transfer
  assign keep_run    = (cfg_start_i == ST_CONT) | stop_cmp1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dcnt_q  <= '0;
      bcnt_q  <= '0;
    end else if (!rx_en_i) begin
      state_q <= S_IDLE;
      dcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (trig) begin
          bcnt_q <= '0;
          if (cfg_delay_i == '0) begin
            state_q <= S_RUN;
          end else begin
            state_q <= S_DELAY;
            dcnt_q  <= cfg_delay_i;
          end
        end
        S_DELAY: if (rck_en_i) begin
          if (dcnt_q == DLY_W'(1)) state_q <= S_RUN;
          dcnt_q <= dcnt_q - DLY_W'(1);
        end
        S_RUN: begin
          if (stop_cmp1 && cmp1_i) begin
            state_q <= S_IDLE;
          end else if (rck_gated_o) begin
            if (bcnt_q == cfg_len_i) begin
              bcnt_q <= '0;
              if (!keep_run) state_q <= S_IDLE;
            end else begin
              bcnt_q <= bcnt_q + LEN_W'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rx_active_o = (state_q == S_RUN);
endmodule

// File: rtl/rx_start_ctrl_chk.sv
`timescale 1ns/1ps
module rx_start_ctrl_chk #(
  parameter int DLY_W = 8,
  parameter int PER_W = 8,
  parameter int LEN_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             rck_en_i,
  input logic             fs_i,
  input logic             tx_start_i,
  input logic             cmp0_i,
  input logic             cmp1_i,
  input logic [3:0]       cfg_start_i,
  input logic             cfg_stop_i,
  input logic [DLY_W-1:0] cfg_delay_i,
  input logic [PER_W-1:0] cfg_period_i,
  input logic [1:0]       cfg_gate_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic             rck_gated_o,
  input logic             rx_active_o,
  input logic             fs_pulse_o
);
  // R1
  gated_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rck_gated_o |-> (rck_en_i && rx_en_i));

  // R1
  gate_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_gate_i == 2'd3) |-> !rck_gated_o);

  // R11
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_active_o);

  // R9
  cmp1_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_active_o && rx_en_i && cfg_start_i == 4'd8 && cfg_stop_i && cmp1_i)
      |=> !rx_active_o);

  // R10
  period_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_period_i == '0) |=> !fs_pulse_o);

  // R10
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_pulse_o |=> !fs_pulse_o);
endmodule

bind rx_start_ctrl rx_start_ctrl_chk #(
  .DLY_W(DLY_W), .PER_W(PER_W), .LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/rx_start_ctrl_bench.sv
`timescale 1ns/1ps
module rx_start_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0, rck_en_i = 1'b1, fs_i = 1'b0;
  logic       tx_start_i = 1'b0, cmp0_i = 1'b0, cmp1_i = 1'b0;
  logic [3:0] cfg_start_i = 4'd9;
  logic       cfg_stop_i = 1'b0;
  logic [7:0] cfg_delay_i = '0, cfg_period_i = '0;
  logic [1:0] cfg_gate_i = '0;
  logic [4:0] cfg_len_i = 5'd3;
  logic       rck_gated_o, rx_active_o, fs_pulse_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rx_start_ctrl u_rx_start_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rck_en_i(rck_en_i),
    .fs_i(fs_i), .tx_start_i(tx_start_i), .cmp0_i(cmp0_i), .cmp1_i(cmp1_i),
    .cfg_start_i(cfg_start_i), .cfg_stop_i(cfg_stop_i), .cfg_delay_i(cfg_delay_i),
    .cfg_period_i(cfg_period_i), .cfg_gate_i(cfg_gate_i), .cfg_len_i(cfg_len_i),
    .rck_gated_o(rck_gated_o), .rx_active_o(rx_active_o), .fs_pulse_o(fs_pulse_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 rx_active_o, 1 fs_pulse_o; counts posedges until seen
  task automatic wait_sig(input int which, input int maxc, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!(which == 1 ? fs_pulse_o : rx_active_o) && n < maxc);
  endtask

  // which: 0 tx_start_i, 1 cmp0_i; one-cycle pulse, count posedges to active
  task automatic pulse_wait(input int which, input int maxc, output int n);
    if (which == 0) tx_start_i = 1'b1; else cmp0_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_start_i = 1'b0; cmp0_i = 1'b0;
    n = 1;
    while (!rx_active_o && n < maxc) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (rx_active_o && n < 100) begin
      n++; @(negedge clk);
    end
  endtask

  task automatic count_active(input int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (rx_active_o) n++;
    end
  endtask

  task automatic setup(input int st, input int stop, input int dly, input int fs);
    rx_en_i = 1'b0;
    cfg_start_i = 4'(st); cfg_stop_i = 1'(stop); cfg_delay_i = 8'(dly);
    cfg_period_i = '0; cfg_gate_i = '0; cfg_len_i = 5'd3;
    fs_i = 1'(fs); rck_en_i = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset;
    chk("R11 reset active", int'(rx_active_o), 0);
    chk("R10 reset pulse", int'(fs_pulse_o), 0);
    chk("R1 reset gated", int'(rck_gated_o), 0);
  endtask

  task automatic t_gate;
    setup(9, 0, 0, 0);
    rx_en_i = 1'b1; cyc(1);
    chk("R1 code0", int'(rck_gated_o), 1);
    cfg_gate_i = 2'd1; cyc(1);
    chk("R1 code1 fs low", int'(rck_gated_o), 1);
    fs_i = 1'b1; cyc(2);
    chk("R1 code1 fs high", int'(rck_gated_o), 0);
    cfg_gate_i = 2'd2; cyc(1);
    chk("R1 code2 fs high", int'(rck_gated_o), 1);
    cfg_gate_i = 2'd3; cyc(1);
    chk("R1 code3", int'(rck_gated_o), 0);
    cfg_gate_i = 2'd0; rck_en_i = 1'b0; cyc(1);
    chk("R1 no tick", int'(rck_gated_o), 0);
    rck_en_i = 1'b1; rx_en_i = 1'b0; cyc(1);
    chk("R1 disabled", int'(rck_gated_o), 0);
  endtask

  task automatic t_cont;
    int n;
    setup(0, 0, 0, 0);
    rx_en_i = 1'b1;
    wait_sig(0, 20, n);
    chk("R2 start latency", n, 1);
    count_active(20, n);
    chk("R2 stays active", n, 20);
    rx_en_i = 1'b0; cyc(1);
    chk("R11 drop clears", int'(rx_active_o), 0);
  endtask

  task automatic t_level;
    int n;
    setup(2, 0, 0, 1);
    rx_en_i = 1'b1; cyc(6);
    chk("R3 low code idle while high", int'(rx_active_o), 0);
    fs_i = 1'b0;
    wait_sig(0, 20, n);
    chk("R3 low start latency", n, 3);
    setup(3, 0, 0, 0);
    rx_en_i = 1'b1; cyc(6);
    chk("R3 high code idle while low", int'(rx_active_o), 0);
    fs_i = 1'b1;
    wait_sig(0, 20, n);
    chk("R3 high start latency", n, 3);
  endtask

  task automatic t_edge;
    int n;
    setup(5, 0, 0, 1);
    rx_en_i = 1'b1; fs_i = 1'b0; cyc(8);
    chk("R4 rise ignores fall", int'(rx_active_o), 0);
    fs_i = 1'b1;
    wait_sig(0, 20, n);
    chk("R4 rise latency", n, 3);
    count_high(n);
    chk("R7 length 4", n, 4);
    cyc(6);
    chk("R4 no retrigger", int'(rx_active_o), 0);
    setup(4, 0, 0, 0);
    rx_en_i = 1'b1; fs_i = 1'b1; cyc(8);
    chk("R4 fall ignores rise", int'(rx_active_o), 0);
    fs_i = 1'b0;
    wait_sig(0, 20, n);
    chk("R4 fall latency", n, 3);
    setup(6, 0, 0, 0);
    cfg_len_i = 5'd6;
    rx_en_i = 1'b1; cyc(4); fs_i = 1'b1;
    wait_sig(0, 20, n);
    chk("R4 change latency", n, 3);
    count_high(n);
    chk("R7 length 7", n, 7);
  endtask

  task automatic t_tx;
    int n;
    setup(1, 0, 0, 0);
    rx_en_i = 1'b1; cyc(3);
    chk("R5 idle before request", int'(rx_active_o), 0);
    pulse_wait(0, 30, n);
    chk("R5 tx latency", n, 1);
    setup(1, 0, 5, 0);
    rx_en_i = 1'b1; cyc(2);
    pulse_wait(0, 30, n);
    chk("R6 delay 5", n, 6);
    setup(1, 0, 8, 0);
    rx_en_i = 1'b1; cyc(2);
    tx_start_i = 1'b1; cyc(1); tx_start_i = 1'b0;
    cyc(3);
    rx_en_i = 1'b0; cyc(1); rx_en_i = 1'b1;
    count_active(15, n);
    chk("R11 pending delay dropped", n, 0);
  endtask

  task automatic t_cmp;
    int n;
    setup(8, 0, 0, 0);
    rx_en_i = 1'b1; cyc(5);
    chk("R8 idle before cmp0", int'(rx_active_o), 0);
    pulse_wait(1, 20, n);
    chk("R8 cmp0 latency", n, 1);
    count_high(n);
    chk("R8 single transfer", n, 4);
    count_active(10, n);
    chk("R8 waits for cmp0", n, 0);
    pulse_wait(1, 20, n);
    chk("R8 rearm", n, 1);
    setup(8, 1, 0, 0);
    rx_en_i = 1'b1; cyc(2);
    pulse_wait(1, 20, n);
    chk("R9 start", n, 1);
    count_active(20, n);
    chk("R9 continuous", n, 20);
    cmp1_i = 1'b1; cyc(1); cmp1_i = 1'b0;
    chk("R9 cmp1 stops", int'(rx_active_o), 0);
    count_active(6, n);
    chk("R9 stays stopped", n, 0);
  endtask

  task automatic t_period;
    int n;
    setup(9, 0, 0, 0);
    cfg_period_i = 8'd2;
    rx_en_i = 1'b1;
    wait_sig(1, 40, n);
    chk("R10 first pulse", n, 6);
    wait_sig(1, 40, n);
    chk("R10 interval", n, 6);
    cyc(3);
    rx_en_i = 1'b0; cyc(1); rx_en_i = 1'b1;
    wait_sig(1, 40, n);
    chk("R11 period restart", n, 6);
    cfg_period_i = 8'd0;
    n = 0;
    repeat (40) begin @(negedge clk); if (fs_pulse_o) n++; end
    chk("R10 zero period", n, 0);
  endtask

  task automatic t_reserved;
    int n;
    setup(9, 0, 0, 0);
    rx_en_i = 1'b1;
    tx_start_i = 1'b1; cmp0_i = 1'b1; fs_i = 1'b1;
    count_active(10, n);
    chk("R12 code 9", n, 0);
    cfg_start_i = 4'd15; fs_i = 1'b0;
    count_active(10, n);
    chk("R12 code 15", n, 0);
    tx_start_i = 1'b0; cmp0_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset;
    rst_ni = 1'b1;
    cyc(2);
    t_gate;
    t_cont;
    t_level;
    t_edge;
    t_tx;
    t_cmp;
    t_period;
    t_reserved;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule